// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog for a system on chip. Software programs it through a simple 32-bit register bus that has four word registers. If software stops restarting it, the block raises either a timed reset pulse or an interrupt level.

Both configuration registers are guarded by key patterns that must appear in the written word. A bus glitch or a runaway store therefore cannot stop the watchdog or reprogram it. The counter is reloaded only when one exact 32-bit restart word is written.

The input clock is divided by one of four prescaler ratios. Each prescaled tick decrements a down-counter. That counter is reloaded with a 12-bit coarse field shifted left by `LOW_W` bits, which makes the reload field × 4096 ticks at the default `LOW_W = 12`. Reaching zero sets a sticky status flag. The flag drives the interrupt level, and it also starts one reset pulse of programmable length.

Top module: `keyed_wdog`

## Requirements
- R1: After block reset, the mode register reads 0, the control register reads 0x0000_3FFC (select 0, coarse field 0xFFF), the status and restart registers read 0, and both outputs are low.
- R2: A write to offset 0x0 is accepted only when wdata[23:12] equals 0xABC; otherwise the stored mode is unchanged. Field positions: bit 0 run enable, bit 1 reset-pulse enable, bit 2 interrupt enable, bits 5:4 pulse-length code. Reads return these bits, with all other bits zero.
- R3: A write to offset 0x4 is accepted only when wdata[31:14] equals 0x00248, which is what a word containing 0x0092_0000 carries; otherwise it is ignored. Field positions: bits 13:2 coarse field, bits 1:0 prescaler select. Reads return these bits, with all other bits zero.
- R4: Writing exactly 0x0000_1999 to offset 0x8 reloads the counter with field << LOW_W, clears the prescaler phase and clears the status flag. Any other value written there has no effect. Offset 0x8 reads as zero.
- R5: Prescaler select codes 0, 1, 2 and 3 give one tick every 8, 64, 512 and 4096 clock cycles respectively.
- R6: While run is enabled, the counter decrements once per tick. With coarse field F and divide D, the status flag (offset 0xC, bit 0) rises exactly F·2^LOW_W·D + 1 cycles after the edge that accepted the restart.
- R7: The status flag stays set until the next valid restart. The interrupt output equals the status flag ANDed with the interrupt enable.
- R8: If the reset-pulse enable is set when the counter expires, the reset output is high for 2, 4, 8 or 16 cycles for pulse codes 0, 1, 2 and 3. It pulses once per expiry.
- R9: A coarse field of 0 followed by a restart sets the status flag on the next clock edge.
- R10: With run enable clear, the counter and prescaler hold, and the block never expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| wd_reset | output | 1 | Timed reset pulse on expiry |
| wd_irq | output | 1 | Interrupt level while expired |

## Verification
Some properties are checked on every cycle. A mode write with a wrong key leaves the mode unchanged. The counter never rises except on a restart. The counter holds while disabled. The status flag is sticky until a restart and clears after one. Ticks occur only while the watchdog is enabled. The interrupt implies the status flag. Every rising edge of the reset pulse follows an expiry event.

Other behaviour can only be shown by the bench scenarios. These cover the exact expiry cycle for each prescaler, the pulse width for each length code, the key patterns on readback, and the rejection of a near-miss restart word.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [3:0]  OFS_MODE = 4'h0;
  localparam logic [3:0]  OFS_CTRL = 4'h4;
  localparam logic [3:0]  OFS_KICK = 4'h8;
  localparam logic [3:0]  OFS_STAT = 4'hC;

  localparam logic [11:0] MODE_KEY = 12'hABC;
  localparam logic [17:0] CTRL_KEY = 18'h00248;
  localparam logic [31:0] KICK_KEY = 32'h0000_1999;

  localparam int FIELD_W = 12;  // coarse reload field, fixed by the register layout
  localparam int MAX_DIV = 4096;
  localparam int PULSE_W = 5;

  typedef struct packed {
    logic [1:0] len;
    logic       irq_en;
    logic       rst_en;
    logic       en;
  } mode_t;

  // clock cycles per prescaled tick
  function automatic int unsigned tick_div(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 64;
      2'd2:    return 512;
      default: return 4096;
    endcase
  endfunction

  // reset pulse width in cycles: 2, 4, 8, 16
  function automatic logic [PULSE_W-1:0] pulse_cycles(input logic [1:0] code);
    return PULSE_W'(2) << code;
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [3:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                expired,
  output logic [31:0]         bus_rdata,
  output mode_t               mode_q,
  output logic [FIELD_W-1:0]  field_q,
  output logic [1:0]          sel_q,
  output logic                kick
);
  logic wr, mode_ok, ctrl_ok;

  assign wr      = bus_sel && bus_we;
  assign mode_ok = wr && (bus_addr == OFS_MODE) && (bus_wdata[23:12] == MODE_KEY);
  assign ctrl_ok = wr && (bus_addr == OFS_CTRL) && (bus_wdata[31:14] == CTRL_KEY);
  assign kick    = wr && (bus_addr == OFS_KICK) && (bus_wdata == KICK_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= '0;
      field_q <= '1;
      sel_q   <= 2'd0;
    end else begin
      if (mode_ok) begin
        mode_q.len    <= bus_wdata[5:4];
        mode_q.irq_en <= bus_wdata[2];
        mode_q.rst_en <= bus_wdata[1];
        mode_q.en     <= bus_wdata[0];
      end
      if (ctrl_ok) begin
        field_q <= bus_wdata[13:2];
        sel_q   <= bus_wdata[1:0];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = {26'b0, mode_q.len, 1'b0, mode_q.irq_en, mode_q.rst_en, mode_q.en};
      OFS_CTRL: bus_rdata = {18'b0, field_q, sel_q};
      OFS_STAT: bus_rdata = {31'b0, expired};
      default:  bus_rdata = 32'b0;
    endcase
  end
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PW = $clog2(MAX_DIV);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim  = PW'(tick_div(sel) - 1);
  // >= keeps the phase bounded if the ratio is lowered mid-count
  assign tick = run && (pre_q >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) pre_q <= '0;
    else if (run)        pre_q <= tick ? '0 : pre_q + PW'(1);
  end
endmodule

// File: rtl/kwd_core.sv
module kwd_core
  import kwd_pkg::*;
#(
  parameter int LOW_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      run,
  input  logic                      kick,
  input  logic [FIELD_W-1:0]        field,
  input  logic                      rst_en,
  input  logic                      irq_en,
  input  logic [1:0]                len,
  output logic [FIELD_W+LOW_W-1:0]  cnt_q,
  output logic                      expired_q,
  output logic                      expire_evt,
  output logic                      rst_out,
  output logic                      irq_out
);
  localparam int CNT_W = FIELD_W + LOW_W;

  logic [PULSE_W-1:0] pulse_q;

  assign expire_evt = run && !kick && !expired_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= {{FIELD_W{1'b1}}, {LOW_W{1'b0}}};
      expired_q <= 1'b0;
      pulse_q   <= '0;
    end else begin
      if (kick)                         cnt_q <= {field, {LOW_W{1'b0}}};
      else if (tick && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);

      if (kick)            expired_q <= 1'b0;
      else if (expire_evt) expired_q <= 1'b1;

      if (expire_evt && rst_en) pulse_q <= pulse_cycles(len);
      else if (pulse_q != '0)   pulse_q <= pulse_q - PULSE_W'(1);
    end
  end

  assign rst_out = (pulse_q != '0);
  assign irq_out = expired_q && irq_en;
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int LOW_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wd_reset,
  output logic        wd_irq
);
  localparam int CNT_W = FIELD_W + LOW_W;

  mode_t              mode_q;
  logic [FIELD_W-1:0] field_q;
  logic [1:0]         sel_q;
  logic               kick;
  logic               tick;
  logic               expire_evt;
  logic               expired_q;
  logic [CNT_W-1:0]   cnt_q;

  kwd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .expired(expired_q),
    .bus_rdata(bus_rdata), .mode_q(mode_q), .field_q(field_q),
    .sel_q(sel_q), .kick(kick)
  );

  kwd_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .run(mode_q.en), .clear(kick),
    .sel(sel_q), .tick(tick)
  );

  kwd_core #(.LOW_W(LOW_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(mode_q.en), .kick(kick),
    .field(field_q), .rst_en(mode_q.rst_en), .irq_en(mode_q.irq_en),
    .len(mode_q.len), .cnt_q(cnt_q), .expired_q(expired_q),
    .expire_evt(expire_evt), .rst_out(wd_reset), .irq_out(wd_irq)
  );
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic             kick,
  input logic             tick,
  input logic             expire_evt,
  input logic             expired_q,
  input logic [CNT_W-1:0] cnt_q,
  input mode_t            mode_q,
  input logic             wd_reset,
  input logic             wd_irq
);
  p_bad_mode_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == 4'h0 && bus_wdata[23:12] != 12'hABC) |=> $stable(mode_q));

  p_kick_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !expired_q);

  p_tick_needs_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> mode_q.en);

  p_no_count_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !kick |=> cnt_q <= $past(cnt_q));

  p_sticky_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && !kick) |=> expired_q);

  p_irq_from_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> expired_q);

  p_pulse_after_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset) |-> $past(expire_evt));

  p_hold_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.en && !kick) |=> $stable(cnt_q));
endmodule

bind keyed_wdog kwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .kick(kick), .tick(tick),
  .expire_evt(expire_evt), .expired_q(expired_q), .cnt_q(cnt_q),
  .mode_q(mode_q), .wd_reset(wd_reset), .wd_irq(wd_irq)
);

// File: tb/keyed_wdog_bench.sv
`timescale 1ns/1ps
module keyed_wdog_bench;
  localparam int LOW_W = 4;  // short reload so every prescaler fits the run

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        wd_reset, wd_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  keyed_wdog #(.LOW_W(LOW_W)) u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wd_reset(wd_reset), .wd_irq(wd_irq)
  );

  // vector: {sel[1:0], len[1:0], field[3:0]}
  localparam int NV = 5;
  localparam logic [7:0] VEC [NV] = '{
    {2'd0, 2'd3, 4'd1},
    {2'd1, 2'd0, 4'd1},
    {2'd2, 2'd1, 4'd1},
    {2'd3, 2'd2, 4'd1},
    {2'd0, 2'd2, 4'd3}
  };

  function automatic int div_for(input int s);
    int d = 8;
    for (int i = 0; i < s; i++) d = d * 8;
    return d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, r); chk("R1 mode", r, 32'h0);
    rd(4'h4, r); chk("R1 ctrl", r, 32'h0000_3FFC);
    rd(4'hC, r); chk("R1 status", r, 32'h0);
    rd(4'h8, r); chk("R1 restart reads zero", r, 32'h0);
    chk("R1 outputs", {30'b0, wd_reset, wd_irq}, 32'h0);

    // R2 mode key
    wr(4'h0, 32'h00AB_B037); rd(4'h0, r); chk("R2 bad key ignored", r, 32'h0);
    wr(4'h0, 32'hFFAB_CFF6); rd(4'h0, r); chk("R2 keyed write, key bits read zero", r, 32'h36);
    wr(4'h0, 32'h00AB_C000); rd(4'h0, r); chk("R2 cleared", r, 32'h0);

    // R3 control key
    wr(4'h4, 32'h0091_0015); rd(4'h4, r); chk("R3 bad key ignored", r, 32'h0000_3FFC);
    wr(4'h4, 32'h0092_0016); rd(4'h4, r); chk("R3 keyed write", r, 32'h16);

    // R5 R6 R8: expiry timing and pulse width per vector
    for (int v = 0; v < NV; v++) begin
      int s, ln, f, n, w;
      s  = int'(VEC[v][7:6]);
      ln = int'(VEC[v][5:4]);
      f  = int'(VEC[v][3:0]);
      n  = f * (1 << LOW_W) * div_for(s) + 1;
      wr(4'h4, 32'h0092_0000 | (f << 2) | s);
      wr(4'h0, 32'h00AB_C007 | (ln << 4));
      wr(4'h8, 32'h0000_1999);
      repeat (n - 1) @(posedge clk);
      #1 chk($sformatf("R5 R6 v%0d irq low one cycle early", v), {31'b0, wd_irq}, 32'h0);
      @(posedge clk); #1;
      chk($sformatf("R6 v%0d irq at expiry cycle", v), {31'b0, wd_irq}, 32'h1);
      w = 0;
      while (wd_reset && w < 40) begin w++; @(posedge clk); #1; end
      chk($sformatf("R8 v%0d pulse width", v), w, 2 << ln);
      repeat (20) @(posedge clk); #1;
      chk($sformatf("R8 v%0d single pulse", v), {31'b0, wd_reset}, 32'h0);
      chk($sformatf("R7 v%0d irq held", v), {31'b0, wd_irq}, 32'h1);
    end

    // R9 zero field expires on next edge
    wr(4'h4, 32'h0092_0000);
    wr(4'h0, 32'h00AB_C005);
    wr(4'h8, 32'h0000_1999);
    chk("R9 cleared after restart", {31'b0, wd_irq}, 32'h0);
    @(posedge clk); #1;
    chk("R9 expired next edge", {31'b0, wd_irq}, 32'h1);
    rd(4'hC, r); chk("R9 status bit", r, 32'h1);

    // R4 near-miss restart word has no effect
    wr(4'h8, 32'h0000_1998);
    chk("R4 wrong restart word ignored", {31'b0, wd_irq}, 32'h1);
    rd(4'hC, r); chk("R4 status kept", r, 32'h1);
    wr(4'h8, 32'h0000_1999);
    chk("R4 valid restart clears irq", {31'b0, wd_irq}, 32'h0);

    // R7 interrupt masked, R8 pulse disabled
    wr(4'h0, 32'h00AB_C001);
    wr(4'h8, 32'h0000_1999);
    repeat (3) @(posedge clk); #1;
    chk("R7 irq masked", {31'b0, wd_irq}, 32'h0);
    chk("R8 no pulse when disabled", {31'b0, wd_reset}, 32'h0);
    rd(4'hC, r); chk("R7 status still set", r, 32'h1);

    // R10 disabled watchdog never expires
    wr(4'h0, 32'h00AB_C004);
    wr(4'h8, 32'h0000_1999);
    repeat (50) @(posedge clk); #1;
    chk("R10 no irq while stopped", {31'b0, wd_irq}, 32'h0);
    rd(4'hC, r); chk("R10 no status while stopped", r, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule